// File: doc/BRIEF.md
# Modulo Overflow Timer with Programmable Reload

This block is a 16-bit up-counter behind a small 32-bit register bus. Software picks a count source (the bus clock itself or an external slow tick), a power-of-two prescale, a terminal count and a start value. The counter advances once per prescaled source event. When it reaches the terminal count, the next step reloads the start value instead of wrapping to zero, and a sticky overflow flag is raised.

A level interrupt follows the flag while the interrupt enable is set. Clearing the flag takes two bus steps: a read of the control word that returns the flag as 1, then a write of 0 to the flag bit. This makes it impossible to lose an overflow that software has not yet seen. Any write to the count register forces the start value into the counter. This gives software a single-step restart.

The typical use is an alarm or periodic wakeup. With a start value of 0, a period of N counts needs a terminal count of N-1.

Top module: `ovf_timer`

## Requirements
- R1: Registers sit at byte offsets 0x00 (control), 0x04 (count), 0x08 (terminal count) and 0x4C (start value). In the control word, bits 2:0 are the prescale code, bits 4:3 the source select, bit 6 the interrupt enable and bit 7 the overflow flag. Every other control bit reads 0. A read returns data on `rdata` one clock after `rd_en`.
- R2: After reset, control reads 0, count reads 0, start value reads 0, terminal count reads 0x0000FFFF, and `irq` is 0.
- R3: Source select 1 gives one source event per bus clock. Source select 2 uses the external tick. Source selects 0 and 3 give no events, and the count holds.
- R4: The counter steps once every 2^P source events, where P is the prescale code (division 1 to 128). A control write whose source field is 0 clears the prescale divider.
- R5: On a step, the counter increments unless it equals the terminal count; in that case it loads the start value. Starting from the start value with a cleared divider, the first overflow falls (terminal − start + 1)·2^P source events after enable.
- R6: The overflow flag is set on the step that takes the counter from the terminal count to the start value.
- R7: A write of any data to the count register loads the start value, and this load wins over a step in the same cycle.
- R8: Writing 0 to flag bit 7 clears the flag only if a control read since the last control write returned the flag as 1. Every control write removes this permission.
- R9: Writing 1 to flag bit 7 leaves the flag unchanged.
- R10: An overflow on the same clock edge as a permitted clear leaves the flag set.
- R11: `irq` is a level equal to flag AND interrupt enable. It drops when either is removed.
- R12: The external tick passes through a two-stage synchronizer. Each low-to-high transition gives exactly one source event, however long the tick stays high.
- R13: Bits 31:16 of the count, terminal count and start value registers read 0, whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered, valid the cycle after `rd_en` |
| tick_in | input | 1 | Asynchronous fixed-frequency tick source |
| irq | output | 1 | Overflow interrupt level |

## Verification
The counting path is exercised in several ways:
- With the bus clock at prescale 0 and 2, the bench measures the exact number of cycles from enable to `irq`. This separates a correct reload-at-terminal from off-by-one counting and from a wrong divider.
- A non-zero start value at prescale 7 shows that the reload comes from the start register and not from zero, and that division by 128 holds the counter still.
- A held-high external tick separates edge detection from level counting.

On the flag path, the bench runs four distinct cases: an unarmed clear, a write of 1, an armed clear, and an armed clear that lands on an overflow edge. These separate the permission and priority rules from a plain write-zero-to-clear flag.

// File: rtl/ovf_timer_pkg.sv
package ovf_timer_pkg;
  localparam logic [7:0] OFS_CTL  = 8'h00;
  localparam logic [7:0] OFS_CNT  = 8'h04;
  localparam logic [7:0] OFS_MOD  = 8'h08;
  localparam logic [7:0] OFS_INIT = 8'h4C;

  localparam int PS_LSB   = 0;
  localparam int SRC_LSB  = 3;
  localparam int IE_BIT   = 6;
  localparam int FLAG_BIT = 7;

  typedef enum logic [1:0] {
    SRC_OFF  = 2'd0,
    SRC_BUS  = 2'd1,
    SRC_TICK = 2'd2,
    SRC_RSVD = 2'd3
  } src_sel_e;
endpackage

// File: rtl/ovf_tick_sync.sv
module ovf_tick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tick_in,
  output logic tick_pulse
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], tick_in};
      last_q <= sync_q[STAGES-1];
    end
  end

  assign tick_pulse = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/ovf_prescale.sv
module ovf_prescale #(
  parameter int PS_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            src_en,
  input  logic [PS_W-1:0] ps,
  output logic            step
);
  localparam int DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  assign mask = DIV_W'((32'd1 << ps) - 32'd1);
  assign step = src_en && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)  div_q <= '0;
    else if (src_en) div_q <= div_q + DIV_W'(1);
  end
endmodule

// File: rtl/ovf_count_core.sv
module ovf_count_core #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] mod_val,
  output logic [CW-1:0] cnt,
  output logic          wrap
);
  logic [CW-1:0] cnt_q;

  assign wrap = step && !load && (cnt_q == mod_val);
  assign cnt  = cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= init_val;
    else if (step) cnt_q <= (cnt_q == mod_val) ? init_val : cnt_q + CW'(1);
  end
endmodule

// File: rtl/ovf_timer.sv
module ovf_timer
  import ovf_timer_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 8,
  parameter int CW          = 16,
  parameter int PS_W        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          tick_in,
  output logic          irq
);
  localparam logic [CW-1:0] MOD_RST = '1;

  logic [PS_W-1:0] ps_q;
  src_sel_e        src_q;
  logic            ie_q, flag_q, armed_q, irq_q;
  logic [CW-1:0]   mod_q, init_q, cnt_q;
  logic [DW-1:0]   rdata_q;

  logic sel_ctl, sel_cnt, sel_mod, sel_init;
  logic wr_ctl, wr_cnt, wr_mod, wr_init;
  logic tick_pulse, src_en, step, wrap, div_clr;
  logic flag_d, ie_d, clr_ok;
  logic [DW-1:0] ctl_word;
  logic wdata_unused;

  assign sel_ctl  = (addr == AW'(OFS_CTL));
  assign sel_cnt  = (addr == AW'(OFS_CNT));
  assign sel_mod  = (addr == AW'(OFS_MOD));
  assign sel_init = (addr == AW'(OFS_INIT));
  assign wr_ctl   = wr_en && sel_ctl;
  assign wr_cnt   = wr_en && sel_cnt;
  assign wr_mod   = wr_en && sel_mod;
  assign wr_init  = wr_en && sel_init;
  assign wdata_unused = &{1'b0, wdata[DW-1:CW]};

  ovf_tick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .tick_in(tick_in), .tick_pulse(tick_pulse)
  );

  always_comb begin
    case (src_q)
      SRC_BUS:  src_en = 1'b1;
      SRC_TICK: src_en = tick_pulse;
      default:  src_en = 1'b0;
    endcase
  end

  assign div_clr = wr_ctl && (wdata[SRC_LSB+1:SRC_LSB] == 2'd0);

  ovf_prescale #(.PS_W(PS_W)) u_pre (
    .clk(clk), .rst(rst), .clr(div_clr), .src_en(src_en), .ps(ps_q), .step(step)
  );

  ovf_count_core #(.CW(CW)) u_core (
    .clk(clk), .rst(rst), .step(step), .load(wr_cnt),
    .init_val(init_q), .mod_val(mod_q), .cnt(cnt_q), .wrap(wrap)
  );

  // Flag: armed clear, set wins over clear
  always_comb begin
    clr_ok = wr_ctl && !wdata[FLAG_BIT] && armed_q;
    flag_d = flag_q;
    if (clr_ok) flag_d = 1'b0;
    if (wrap)   flag_d = 1'b1;
    ie_d = wr_ctl ? wdata[IE_BIT] : ie_q;
  end

  always_comb begin
    ctl_word = '0;
    ctl_word[PS_LSB +: PS_W]  = ps_q;
    ctl_word[SRC_LSB +: 2]    = src_q;
    ctl_word[IE_BIT]          = ie_q;
    ctl_word[FLAG_BIT]        = flag_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ps_q    <= '0;
      src_q   <= SRC_OFF;
      ie_q    <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
      irq_q   <= 1'b0;
      mod_q   <= MOD_RST;
      init_q  <= '0;
      rdata_q <= '0;
    end else begin
      flag_q <= flag_d;
      ie_q   <= ie_d;
      irq_q  <= flag_d & ie_d;
      if (wr_ctl) begin
        ps_q  <= wdata[PS_LSB +: PS_W];
        src_q <= src_sel_e'(wdata[SRC_LSB +: 2]);
      end
      if (wr_mod)  mod_q  <= wdata[CW-1:0];
      if (wr_init) init_q <= wdata[CW-1:0];
      if (wr_ctl)                          armed_q <= 1'b0;
      else if (rd_en && sel_ctl && flag_q) armed_q <= 1'b1;
      if (rd_en) begin
        if (sel_ctl)       rdata_q <= ctl_word;
        else if (sel_cnt)  rdata_q <= DW'(cnt_q);
        else if (sel_mod)  rdata_q <= DW'(mod_q);
        else if (sel_init) rdata_q <= DW'(init_q);
        else               rdata_q <= '0;
      end
    end
  end

  assign rdata = rdata_q;
  assign irq   = irq_q;
endmodule

// File: rtl/ovf_timer_chk.sv
module ovf_timer_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          flag,
  input logic          ie,
  input logic          wrap,
  input logic          step,
  input logic          cnt_wr,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] init
);
  // R11
  irq_level_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (flag & ie));

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> flag);

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == $past(init)));

  // R7
  cnt_load_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_wr |=> (cnt == $past(init)));

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!step && !cnt_wr) |=> $stable(cnt));
endmodule

bind ovf_timer ovf_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .flag(flag_q), .ie(ie_q),
  .wrap(wrap), .step(step), .cnt_wr(wr_cnt), .cnt(cnt_q), .init(init_q)
);

// File: tb/ovf_timer_bench.sv
module ovf_timer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0, tick_in = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int checks = 0;
  int errors = 0;

  localparam logic [7:0] A_CTL = 8'h00, A_CNT = 8'h04, A_MOD = 8'h08, A_INIT = 8'h4C;

  always #10 clk = ~clk;

  ovf_timer u_ovf_timer (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .tick_in(tick_in), .irq(irq)
  );

  function automatic logic [31:0] ctl(input int ps, input int src, input bit ie, input bit fl);
    return 32'(ps) | (32'(src) << 3) | (32'(ie) << 6) | (32'(fl) << 7);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic cycles_to_irq(input int limit, output int n);
    n = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irq) begin n = i; break; end
    end
  endtask

  task automatic restart(input logic [31:0] m, input logic [31:0] ini);
    logic [31:0] d;
    bus_wr(A_CTL, ctl(0, 0, 0, 0));
    bus_rd(A_CTL, d);
    if (d[7]) bus_wr(A_CTL, ctl(0, 0, 0, 0));
    bus_wr(A_MOD, m);
    bus_wr(A_INIT, ini);
    bus_wr(A_CNT, 32'h0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R2 irq", 32'(irq), 32'd0);
    bus_rd(A_CTL, d);  check("R2 ctl", d, 32'h0);
    bus_rd(A_CNT, d);  check("R2 cnt", d, 32'h0);
    bus_rd(A_MOD, d);  check("R2 mod", d, 32'h0000FFFF);
    bus_rd(A_INIT, d); check("R2 init", d, 32'h0);
  endtask

  task automatic t_fields;
    logic [31:0] d;
    bus_wr(A_CTL, ctl(5, 3, 1, 0) | 32'hFFFF_FF20);
    bus_rd(A_CTL, d); check("R1 ctl fields", d, ctl(5, 3, 1, 0));
    bus_wr(A_MOD, 32'hFFFF_1234);
    bus_rd(A_MOD, d); check("R13 mod upper", d, 32'h1234);
    bus_wr(A_INIT, 32'hABCD_0055);
    bus_rd(A_INIT, d); check("R13 init upper", d, 32'h0055);
    bus_wr(A_CNT, 32'hDEAD_BEEF);
    bus_rd(A_CNT, d); check("R7 cnt write loads init", d, 32'h0055);
    repeat (20) @(negedge clk);
    bus_rd(A_CNT, d); check("R3 select 3 holds", d, 32'h0055);
  endtask

  task automatic t_bus_count;
    int n;
    restart(32'd4, 32'd0);
    bus_wr(A_CTL, ctl(0, 1, 1, 0));
    cycles_to_irq(200, n); check("R5 R6 period ps0 mod4", 32'(n), 32'd5);
    restart(32'd2, 32'd0);
    bus_wr(A_CTL, ctl(2, 1, 1, 0));
    cycles_to_irq(200, n); check("R4 period ps2 mod2", 32'(n), 32'd12);
  endtask

  task automatic t_reload;
    int n;
    logic [31:0] d;
    restart(32'h12, 32'h10);
    bus_rd(A_CNT, d); check("R7 loaded start", d, 32'h10);
    bus_wr(A_CTL, ctl(7, 1, 1, 0));
    cycles_to_irq(1000, n); check("R4 R5 period ps7", 32'(n), 32'd384);
    bus_wr(A_CTL, ctl(0, 0, 1, 0));
    bus_rd(A_CNT, d); check("R5 reload to start", d, 32'h10);
    repeat (10) @(negedge clk);
    bus_rd(A_CNT, d); check("R3 select 0 holds", d, 32'h10);
  endtask

  task automatic t_tick;
    logic [31:0] d;
    restart(32'd1, 32'd0);
    bus_wr(A_CTL, ctl(0, 2, 1, 0));
    @(negedge clk); tick_in = 1'b1;
    repeat (8) @(negedge clk); tick_in = 1'b0;
    repeat (5) @(negedge clk);
    check("R12 one edge no irq", 32'(irq), 32'd0);
    bus_rd(A_CNT, d); check("R12 held high counts once", d, 32'd1);
    tick_in = 1'b1;
    repeat (6) @(negedge clk); tick_in = 1'b0;
    repeat (4) @(negedge clk);
    check("R12 R6 second edge overflow", 32'(irq), 32'd1);
    bus_rd(A_CNT, d); check("R5 tick reload", d, 32'd0);
  endtask

  task automatic t_clear;
    logic [31:0] d;
    bus_wr(A_CTL, ctl(0, 0, 1, 0));
    check("R8 unarmed clear ignored", 32'(irq), 32'd1);
    bus_wr(A_CTL, ctl(0, 0, 0, 0));
    check("R11 enable gates irq", 32'(irq), 32'd0);
    bus_rd(A_CTL, d); check("R11 flag kept", d, ctl(0, 0, 0, 1));
    bus_wr(A_CTL, ctl(0, 0, 1, 1));
    check("R9 write one no effect", 32'(irq), 32'd1);
    bus_rd(A_CTL, d); check("R9 ctl", d, ctl(0, 0, 1, 1));
    bus_wr(A_CTL, ctl(0, 0, 1, 0));
    check("R8 armed clear", 32'(irq), 32'd0);
    bus_rd(A_CTL, d); check("R8 ctl after clear", d, ctl(0, 0, 1, 0));
  endtask

  task automatic t_race;
    logic [31:0] d;
    restart(32'd0, 32'd0);
    bus_wr(A_CTL, ctl(1, 1, 1, 0));
    repeat (4) @(negedge clk);
    bus_rd(A_CTL, d); check("R10 flag seen", 32'(d[7]), 32'd1);
    bus_wr(A_CTL, ctl(1, 1, 1, 0));
    check("R10 overflow beats clear", 32'(irq), 32'd1);
    bus_wr(A_CTL, ctl(0, 0, 0, 0));
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_fields;
    t_bus_count;
    t_reload;
    t_tick;
    t_clear;
    t_race;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule